// File: doc/BRIEF.md
# Opcode-Programmed SPI Master

This block is an SPI master whose bus activity comes from a small program rather than from one register write per byte. Software loads a 64-bit program word holding eight one-byte opcodes, and the interpreter runs them one after another. The opcodes can pick or drop a target, move up to eight bytes out of a 64-bit transmit register, gather up to eight bytes into a 64-bit receive register, copy the transmit register into the receive register, jump back under a loop counter, or halt.

Software works through a plain register write port, a receive-pop strobe and a read-only status word. The status word carries the interpreter state, the two data-register full flags and four error flags. Each data register has a full flag that paces the program. A shift-out waits until the transmit register has been filled, and a shift-in waits until the receive register has been emptied. A counted branch therefore streams many words through one short program.

Top module: `opseq_spi_master`

## Requirements
- R1: Slots execute in order from slot 0 (program bits 63:56) to slot 7 (bits 7:0). Opcode 0x00 halts the program. After slot 7 runs without a branch, the block returns to idle with the program counter at 0.
- R2: A program-word write (address 7) starts execution at slot 0. It is accepted only while the block is idle and is ignored otherwise.
- R3: Opcode 0x1n selects target n. Target k+1 drives cs_n[k] low and every other chip select high, and target 0 deselects all. At most one chip select is low at any time, and SCK toggles only while a target is selected.
- R4: The counter configuration (address 1) holds the loop count in bits 39:32. Opcode 0xEn jumps to slot n while the count is non-zero and decrements the count on each jump. When the count is zero, the branch falls through to the next slot.
- R5: Counter configuration bit 11 enables auto-reload: a branch that falls through reloads the loop count. Bit 10 enables implicit mode: a shift-out then neither waits for nor clears the transmit full flag.
- R6: Opcode 0x3n shifts out n bytes (n above 8 counts as 8), starting with the most significant byte of the transmit register and MSB first. Opcode 0x4n shifts in n bytes, and the first byte received lands in the highest used byte of the receive register. A zero count does nothing.
- R7: Status bits 55:48 give the interpreter state: 0x01 idle, 0x02 executing, 0x04 waiting on a data register, 0x08 shifting. After reset the status reads 0x0001_0000_0000_0000.
- R8: A transmit write (address 5) sets status bit 59. A shift-out waits for bit 59 and clears it once its last byte is sent. A completed shift-in sets bit 63, and a pulse on rx_pop clears it.
- R9: Error flags: bit 58 is set by a transmit write while bit 59 is set, and that write is dropped. Bit 61 is set by rx_pop while bit 63 is clear. Opcode 0xC0 copies the transmit register into the receive register and sets bit 63. It sets bit 57 if the transmit register was empty and bit 62 if the receive register was already full.
- R10: Clock configuration (address 3) bits 63:52 set the divider, so each SCK phase lasts divider+1 clocks. Bit 51 set samples MISO on the rising SCK edge, and bit 51 clear samples it on the falling edge. Both settings return the same data from a target that changes MISO on the falling edge.
- R11: A shift-in opcode stalls, with no SCK activity, while the receive register is full. Data held in a full receive register does not change until it is popped.
- R12: Writing zero to the status register (address 8) clears all four error flags, stops any transfer, and returns the block to idle at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (1 counter, 3 clock, 5 transmit, 7 program, 8 status) |
| wr_data | input | 64 | Register write data |
| rx_pop | input | 1 | Consumes the receive register |
| status | output | 64 | Status word |
| rx_data | output | 64 | Receive register |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Register and status effects appear one clock after the write or pop edge, so the bench reads them at the falling clock edge that follows. Serial results take longer: each byte needs 16 SCK phases of divider+1 clocks each, plus one cycle to load and one to leave. The bench therefore does not fix a cycle count for them. It waits for the idle state code, then compares the bytes its behavioural target model captured with queues built from the requirements. A per-clock monitor checks that SCK never toggles with no target selected, records which chip selects were low while SCK was high, and measures the length of the SCK high phase.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EXEC  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_SHIFT = 2'd3
   } seq_st_e;

   localparam logic [3:0] ADR_CNT  = 4'd1;
   localparam logic [3:0] ADR_CLK  = 4'd3;
   localparam logic [3:0] ADR_TX   = 4'd5;
   localparam logic [3:0] ADR_PROG = 4'd7;
   localparam logic [3:0] ADR_STAT = 4'd8;

   localparam logic [3:0] OPG_CTRL = 4'h0;
   localparam logic [3:0] OPG_SEL  = 4'h1;
   localparam logic [3:0] OPG_OUT  = 4'h3;
   localparam logic [3:0] OPG_IN   = 4'h4;
   localparam logic [3:0] OPG_COPY = 4'hC;
   localparam logic [3:0] OPG_JUMP = 4'hE;
endpackage

// File: rtl/opseq_clkdiv.sv
module opseq_clkdiv #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (tick)     cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/opseq_shifter.sv
module opseq_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              late,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              busy,
   output logic              done,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam int PH_W   = $clog2(2 * BYTE_W);
   localparam int LAST_P = 2 * BYTE_W - 1;

   logic [BYTE_W-1:0] sh_q;
   logic [PH_W-1:0]   ph_q;

   assign mosi = sh_q[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0; ph_q <= '0; busy <= 1'b0; sck <= 1'b0;
         done <= 1'b0; rx_byte <= '0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            busy <= 1'b0; sck <= 1'b0;
         end else if (start) begin
            sh_q <= tx_byte; ph_q <= '0; busy <= 1'b1; sck <= 1'b0;
         end else if (busy && tick) begin
            ph_q <= ph_q + 1'b1;
            if (!ph_q[0]) begin
               sck <= 1'b1;
               if (!late) rx_byte <= {rx_byte[BYTE_W-2:0], miso};
            end else begin
               sck <= 1'b0;
               if (late) rx_byte <= {rx_byte[BYTE_W-2:0], miso};
               if (ph_q == PH_W'(LAST_P)) begin
                  busy <= 1'b0; done <= 1'b1;
               end else begin
                  sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assert_sck_in_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> busy);
endmodule

// File: rtl/opseq_loopctr.sv
module opseq_loopctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             load_reload,
   input  logic             take,
   output logic             taken
);
   logic [CNT_W-1:0] cfg_q, cnt_q;
   logic             rel_q;

   assign taken = take && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0; cnt_q <= '0; rel_q <= 1'b0;
      end else if (load) begin
         cfg_q <= load_cnt; cnt_q <= load_cnt; rel_q <= load_reload;
      end else if (take) begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         else if (rel_q)  cnt_q <= cfg_q;
      end
   end

   assert_loop_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !load && cnt_q == '0 && rel_q) |=> (cnt_q == cfg_q));
endmodule

// File: rtl/opseq_spi_master.sv
module opseq_spi_master
   import opseq_pkg::*;
#(
   parameter int NCS          = 4,
   parameter int DIV_W        = 12,
   parameter int LOOP_W       = 8,
   parameter bit HAS_RX_DELAY = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [3:0]     wr_addr,
   input  logic [63:0]    wr_data,
   input  logic           rx_pop,
   output logic [63:0]    status,
   output logic [63:0]    rx_data,
   output logic           sck,
   output logic           mosi,
   input  logic           miso,
   output logic [NCS-1:0] cs_n
);
   localparam int BYTE_W  = 8;
   localparam int SLOTS   = 8;
   localparam int PC_W    = $clog2(SLOTS);
   localparam int MAXB    = 64 / BYTE_W;
   localparam int LEFT_W  = $clog2(MAXB) + 1;

   if (NCS < 1 || NCS > 15) begin : g_bad_ncs
      $error("NCS must lie in 1..15");
   end
   if (DIV_W < 1 || DIV_W > 12) begin : g_bad_div
      $error("DIV_W must lie in 1..12");
   end
   if (LOOP_W < 1 || LOOP_W > 8) begin : g_bad_loop
      $error("LOOP_W must lie in 1..8");
   end

   seq_st_e            st_q, adv_st;
   logic [63:0]        prog_q, tx_q, rx_q, acc_q;
   logic [PC_W-1:0]    pc_q, adv_pc;
   logic               tx_full_q, rx_full_q, txu_q, txo_q, rxu_q, rxo_q;
   logic               impl_q, nodel_q, dir_in_q;
   logic [DIV_W-1:0]   div_q;
   logic [3:0]         tgt_q;
   logic [LEFT_W-1:0]  left_q;
   logic [PC_W-1:0]    bidx_q;

   logic [7:0] op;
   logic [3:0] op_hi, op_lo;
   logic [LEFT_W-1:0] op_n;
   logic [7:0] st_code;
   logic in_exec, jump_req, jump_taken, copy_fire, clr_all, sh_ready, sh_start;
   logic sh_busy, sh_done, sh_tick, sh_late;
   logic [BYTE_W-1:0] sh_tx, sh_rx;

   assign op      = prog_q[{~pc_q, 3'b000} +: 8];
   assign op_hi   = op[7:4];
   assign op_lo   = op[3:0];
   assign op_n    = (op_lo > 4'(MAXB)) ? LEFT_W'(MAXB) : LEFT_W'(op_lo);
   assign in_exec = (st_q == ST_EXEC);
   assign jump_req  = in_exec && (op_hi == OPG_JUMP);
   assign copy_fire = in_exec && (op == {OPG_COPY, 4'h0});
   assign clr_all   = wr_en && (wr_addr == ADR_STAT) && (wr_data == 64'd0);
   assign sh_ready  = dir_in_q ? !rx_full_q : (tx_full_q || impl_q);
   assign sh_start  = (st_q == ST_WAIT) && sh_ready && !clr_all;
   assign sh_tx     = dir_in_q ? '0 : tx_q[{~bidx_q, 3'b000} +: 8];
   assign adv_st    = (pc_q == PC_W'(SLOTS - 1)) ? ST_IDLE : ST_EXEC;
   assign adv_pc    = (pc_q == PC_W'(SLOTS - 1)) ? '0 : pc_q + 1'b1;

   if (HAS_RX_DELAY) begin : g_dly
      assign sh_late = ~nodel_q;
   end else begin : g_nodly
      assign sh_late = 1'b0;
   end

   for (genvar k = 0; k < NCS; k++) begin : g_cs
      assign cs_n[k] = (tgt_q != 4'(k + 1));
   end

   opseq_clkdiv #(.DIV_W(DIV_W)) i_div (
      .clk(clk), .rst_n(rst_n), .run(sh_busy), .div(div_q), .tick(sh_tick));

   opseq_shifter #(.BYTE_W(BYTE_W)) i_shf (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .abort(clr_all),
      .tx_byte(sh_tx), .tick(sh_tick), .late(sh_late), .miso(miso),
      .sck(sck), .mosi(mosi), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx));

   opseq_loopctr #(.CNT_W(LOOP_W)) i_loop (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en && wr_addr == ADR_CNT),
      .load_cnt(wr_data[32 +: LOOP_W]), .load_reload(wr_data[11]),
      .take(jump_req), .taken(jump_taken));

   always_comb begin
      unique case (st_q)
         ST_IDLE:  st_code = 8'h01;
         ST_EXEC:  st_code = 8'h02;
         ST_WAIT:  st_code = 8'h04;
         default:  st_code = 8'h08;
      endcase
   end

   assign status  = {rx_full_q, rxo_q, rxu_q, 1'b0, tx_full_q, txo_q, txu_q, 1'b0,
                     st_code, 48'd0};
   assign rx_data = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; pc_q <= '0; prog_q <= '0; tx_q <= '0; rx_q <= '0;
         acc_q <= '0; tx_full_q <= 1'b0; rx_full_q <= 1'b0;
         txu_q <= 1'b0; txo_q <= 1'b0; rxu_q <= 1'b0; rxo_q <= 1'b0;
         impl_q <= 1'b0; nodel_q <= 1'b1; div_q <= '0; tgt_q <= '0;
         dir_in_q <= 1'b0; left_q <= '0; bidx_q <= '0;
      end else begin
         if (rx_pop) begin
            if (rx_full_q) rx_full_q <= 1'b0;
            else           rxu_q <= 1'b1;
         end
         unique case (st_q)
            ST_EXEC: begin
               unique case (op_hi)
                  OPG_CTRL: begin
                     if (op_lo == 4'h0) begin st_q <= ST_IDLE; pc_q <= '0; end
                     else begin st_q <= adv_st; pc_q <= adv_pc; end
                  end
                  OPG_SEL: begin
                     tgt_q <= op_lo; st_q <= adv_st; pc_q <= adv_pc;
                  end
                  OPG_OUT, OPG_IN: begin
                     if (op_lo == 4'h0) begin st_q <= adv_st; pc_q <= adv_pc; end
                     else begin
                        left_q <= op_n; bidx_q <= '0; acc_q <= '0;
                        dir_in_q <= (op_hi == OPG_IN); st_q <= ST_WAIT;
                     end
                  end
                  OPG_JUMP: begin
                     if (jump_taken) pc_q <= op_lo[PC_W-1:0];
                     else begin st_q <= adv_st; pc_q <= adv_pc; end
                  end
                  default: begin
                     if (copy_fire) begin
                        if (!tx_full_q) txu_q <= 1'b1;
                        if (rx_full_q)  rxo_q <= 1'b1;
                        rx_q <= tx_q; rx_full_q <= 1'b1; tx_full_q <= 1'b0;
                     end
                     st_q <= adv_st; pc_q <= adv_pc;
                  end
               endcase
            end
            ST_WAIT: if (sh_start) st_q <= ST_SHIFT;
            ST_SHIFT: begin
               if (sh_done) begin
                  bidx_q <= bidx_q + 1'b1;
                  left_q <= left_q - 1'b1;
                  if (dir_in_q) acc_q <= {acc_q[55:0], sh_rx};
                  if (left_q == LEFT_W'(1)) begin
                     if (dir_in_q) begin
                        rx_q <= {acc_q[55:0], sh_rx}; rx_full_q <= 1'b1;
                     end else if (!impl_q) begin
                        tx_full_q <= 1'b0;
                     end
                     st_q <= adv_st; pc_q <= adv_pc;
                  end else begin
                     st_q <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
         if (wr_en) begin
            unique case (wr_addr)
               ADR_CLK: begin div_q <= wr_data[52 +: DIV_W]; nodel_q <= wr_data[51]; end
               ADR_CNT: impl_q <= wr_data[10];
               ADR_TX: begin
                  if (tx_full_q) txo_q <= 1'b1;
                  else begin tx_q <= wr_data; tx_full_q <= 1'b1; end
               end
               ADR_PROG: if (st_q == ST_IDLE) begin
                  prog_q <= wr_data; pc_q <= '0; st_q <= ST_EXEC;
               end
               ADR_STAT: if (clr_all) begin
                  txu_q <= 1'b0; txo_q <= 1'b0; rxu_q <= 1'b0; rxo_q <= 1'b0;
                  st_q <= ST_IDLE; pc_q <= '0;
               end
               default: ;
            endcase
         end
      end
   end

   assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !sck);
   assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full_q && !rx_pop && !copy_fire) |=> $stable(rx_q));
   assert_stall_no_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && dir_in_q && rx_full_q) |=> !sh_busy);
endmodule

// File: tb/test_opseq_spi_master.sv
module test_opseq_spi_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic        rx_pop = 1'b0;
   logic [63:0] status, rx_data;
   logic        sck, mosi, miso;
   logic [3:0]  cs_n;

   int nchk = 0, nbad = 0;

   opseq_spi_master i_opseq_spi_master (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rx_pop(rx_pop), .status(status), .rx_data(rx_data), .sck(sck), .mosi(mosi),
      .miso(miso), .cs_n(cs_n));

   always #4 clk = ~clk;

   // behavioural SPI target: captures MOSI on rising SCK, changes MISO on falling SCK
   logic [7:0] out_q[$];
   logic [7:0] in_q[$];
   logic [7:0] cap = '0, cur = '0;
   int capn = 0, bitp = 0;
   assign miso = cur[7 - bitp];

   always @(posedge sck) begin
      cap = {cap[6:0], mosi};
      capn++;
      if (capn == 8) begin out_q.push_back(cap); capn = 0; end
   end
   always @(negedge sck) begin
      if (bitp == 7) begin
         bitp = 0;
         cur = (in_q.size() > 0) ? in_q.pop_front() : 8'h00;
      end else bitp++;
   end

   // per-clock monitor
   int stray = 0, hi_run = 0, last_hi = 0;
   logic [3:0] seen = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sck && (&cs_n)) stray++;
         if (sck) begin seen |= ~cs_n; hi_run++; end
         else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pop();
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   function automatic logic is_idle();
      return status[55:48] == 8'h01;
   endfunction

   task automatic run(input logic [63:0] prog, input logic [63:0] feed[$]);
      wr(4'd7, prog);
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (is_idle()) break;
         if (!status[59] && feed.size() > 0) begin
            wr_en = 1'b1; wr_addr = 4'd5; wr_data = feed.pop_front();
            @(negedge clk); wr_en = 1'b0;
         end
      end
   endtask

   task automatic chk_bytes(input string tag, input logic [7:0] exp[$]);
      chk({tag, " count"}, 64'(out_q.size()), 64'(exp.size()));
      foreach (exp[i]) if (i < out_q.size()) chk({tag, " byte"}, 64'(out_q[i]), 64'(exp[i]));
      out_q.delete();
   endtask

   task automatic preload(input logic [7:0] b[$]);
      in_q = b; cur = in_q.pop_front(); bitp = 0;
   endtask

   initial begin
      #(8 * 150000);
      nbad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nchk + 1, nbad);
      $finish;
   end

   initial begin
      logic [63:0] none[$];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 reset status", status, 64'h0001_0000_0000_0000);
      chk("R3 reset selects", 64'(cs_n), 64'hF);

      // R6 R8: two bytes out to target 1
      wr(4'd5, 64'hC35A_0000_0000_0000);
      chk("R8 tx full set", 64'(status[59]), 64'd1);
      seen = '0;
      run(64'h1132_1000_0000_0000, none);
      chk_bytes("R6 shift out", '{8'hC3, 8'h5A});
      chk("R3 target1 select", 64'(seen), 64'h1);
      chk("R8 tx full cleared", 64'(status[59]), 64'd0);

      // R6 shift in three bytes
      preload('{8'hA1, 8'hB2, 8'hC3});
      run(64'h1143_1000_0000_0000, none);
      out_q.delete();
      chk("R6 shift in order", rx_data, 64'h0000_0000_00A1_B2C3);
      chk("R8 rx full set", 64'(status[63]), 64'd1);

      // R11 stall while rx full, R2 program write ignored while busy
      preload('{8'h5E});
      seen = '0;
      wr(4'd7, 64'h1141_1000_0000_0000);
      repeat (40) @(negedge clk);
      chk("R11 waiting state", 64'(status[55:48]), 64'h04);
      chk("R11 no clocks while stalled", 64'(out_q.size()), 64'd0);
      chk("R11 rx held", rx_data, 64'h0000_0000_00A1_B2C3);
      wr(4'd7, 64'h1331_1000_0000_0000);
      pop();
      for (int i = 0; i < 2000 && !is_idle(); i++) @(negedge clk);
      out_q.delete();
      chk("R11 rx after stall", rx_data, 64'h0000_0000_0000_005E);
      chk("R2 busy program write ignored", 64'(seen), 64'h1);
      pop();

      // R4 R5 loop with reload: count 2, reload on
      wr(4'd1, (64'd2 << 32) | (64'd1 << 11));
      run(64'h1131_E110_0000_0000, '{64'hAA00_0000_0000_0000, 64'hBB00_0000_0000_0000,
                                      64'hCC00_0000_0000_0000});
      chk_bytes("R4 loop three passes", '{8'hAA, 8'hBB, 8'hCC});
      run(64'h1131_E110_0000_0000, '{64'hDD00_0000_0000_0000, 64'hEE00_0000_0000_0000,
                                      64'hF000_0000_0000_0000});
      chk_bytes("R5 reloaded loop", '{8'hDD, 8'hEE, 8'hF0});

      // R4 R5 loop without reload
      wr(4'd1, 64'd1 << 32);
      run(64'h1131_E110_0000_0000, '{64'h1100_0000_0000_0000, 64'h2200_0000_0000_0000});
      chk_bytes("R4 loop count one", '{8'h11, 8'h22});
      run(64'h1131_E110_0000_0000, '{64'h3344_0000_0000_0000});
      chk_bytes("R5 exhausted no reload", '{8'h33});

      // R5 implicit mode reuses transmit register
      wr(4'd1, 64'd1 << 10);
      run(64'h1132_1000_0000_0000, none);
      chk_bytes("R5 implicit send", '{8'h33, 8'h44});
      chk("R5 implicit keeps flag clear", 64'(status[59]), 64'd0);
      wr(4'd1, 64'd0);

      // R9 transmit overrun drops second write
      wr(4'd5, 64'h99AB_CDEF_0123_4567);
      wr(4'd5, 64'h7700_0000_0000_0000);
      chk("R9 tx overrun", 64'(status[58]), 64'd1);
      run(64'h1131_1000_0000_0000, none);
      chk_bytes("R9 first word kept", '{8'h99});

      // R9 receive underrun
      pop();
      chk("R9 rx underrun", 64'(status[61]), 64'd1);

      // R9 copy with empty transmit, then copy onto full receive
      run(64'hC000_0000_0000_0000, none);
      chk("R9 tx underrun on copy", 64'(status[57]), 64'd1);
      chk("R9 copied data", rx_data, 64'h99AB_CDEF_0123_4567);
      run(64'hC000_0000_0000_0000, none);
      chk("R9 rx overrun on copy", 64'(status[62]), 64'd1);

      // R12 clear
      wr(4'd8, 64'd0);
      chk("R12 cleared status", status, 64'h8001_0000_0000_0000);
      pop();

      // R3 target 3 and deselect
      seen = '0;
      run(64'h1331_1000_0000_0000, '{64'h4200_0000_0000_0000});
      chk_bytes("R3 target3 data", '{8'h42});
      chk("R3 target3 select", 64'(seen), 64'h4);
      chk("R3 deselected", 64'(cs_n), 64'hF);

      // R1 halt opcode stops before later slots
      wr(4'd5, 64'h5500_0000_0000_0000);
      run(64'h1100_3100_0000_0000, none);
      chk("R1 halted idle", 64'(is_idle()), 64'd1);
      chk("R1 later slot not run", 64'(status[59]), 64'd1);
      chk("R3 select held after halt", 64'(cs_n), 64'hE);
      run(64'h1131_1000_0000_0000, none);
      chk_bytes("R1 resumed send", '{8'h55});

      // R1 eight slots without halt end idle
      run(64'h1110_1110_1110_1110, none);
      chk("R1 end after slot 7", 64'(is_idle()), 64'd1);
      chk("R1 final slot ran", 64'(cs_n), 64'hF);

      // R10 divider 3 with falling-edge sampling
      wr(4'd3, 64'd3 << 52);
      preload('{8'h6C});
      run(64'h1141_1000_0000_0000, none);
      out_q.delete();
      chk("R10 sck phase length", 64'(last_hi), 64'd4);
      chk("R10 delayed sample data", rx_data, 64'h0000_0000_0000_006C);
      pop();

      chk("R3 no clock without select", 64'(stray), 64'd0);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule